// File: doc/BRIEF.md
# Power-Cycle Burst Profile Selector

This block picks which of three USB identity profiles a boot-memory emulator presents to its host controller. The only user control is the supply itself. A short burst of quick power-ups advances the selection by one step. An ordinary single plug-in leaves it unchanged. The profiles follow a fixed ring: "no memory" (the host falls back to its built-in descriptor), then identity one (VID 0x04B4, PID 0x8613), then identity two (VID 0x0925, PID 0x3881), then back to "no memory".

A power-up is the rising edge of `power_ok`, sampled on the free-running time-base clock `clk`. The profile, the burst counter and the window timer all stand in for retained (nonvolatile) storage. Only `store_init_n` clears them, and a loss of power leaves them as they are. The window length is `TICKS_PER_SEC * WINDOW_SEC` clock cycles and is measured from the first power-up of a burst. `BURST_LEN` power-ups inside that window advance the profile once.

A two-state machine tracks each burst:
- BS_IDLE: no burst is open.
- BS_OPEN: a burst is open and is counting.

The machine has four transitions:
- open: BS_IDLE to BS_OPEN, on a power-up. The count becomes 1 and the timer restarts.
- count: BS_OPEN to BS_OPEN, on a power-up that leaves the count below `BURST_LEN`.
- advance: BS_OPEN to BS_IDLE, on the power-up that completes the burst. The profile steps once and the count clears.
- expire: BS_OPEN to BS_IDLE, when the timer reaches the end of the window without a power-up. The count clears.

Top module: `pcsel_top`

## Requirements
- R1: While `store_init_n` is low and after its release, the profile code is 0 and `vid`/`pid` are both 0x0000.
- R2: Profile code 0 drives `vid`=`pid`=0x0000. Code 1 drives `vid`=0x04B4 and `pid`=0x8613. Code 2 drives `vid`=0x0925 and `pid`=0x3881. Code 3 never appears.
- R3: A power-up that does not complete a burst of `BURST_LEN` leaves the profile unchanged.
- R4: A power-up is the clock edge at which `power_ok` is sampled high after being sampled low at the previous edge. Let W be the window length in cycles. The power-up that completes `BURST_LEN` power-ups, with every one of them at most W cycles after the first, changes the profile code at that same clock edge.
- R5: Each advance moves one step around the ring 0 to 1 to 2 to 0.
- R6: A power-up more than W cycles after the first power-up of the open burst discards that burst and starts a new one, with a count of 1.
- R7: A run of quick power-ups longer than `BURST_LEN` but shorter than 2*`BURST_LEN` advances the profile exactly once. Counting restarts after each advance.
- R8: Holding `power_ok` low for any number of cycles changes neither the profile nor the outputs.
- R9: Holding `power_ok` high counts as a single power-up, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running time base; one cycle is one tick |
| store_init_n | input | 1 | Asynchronous low initialisation of the retained storage |
| power_ok | input | 1 | Supply-good level; a rising edge is a power-up |
| prof_code | output | 2 | Selected profile: 0 none, 1 identity one, 2 identity two |
| vid | output | 16 | Vendor ID presented for the profile |
| pid | output | 16 | Product ID presented for the profile |

## Verification
A wrong burst count or a timer that drifts from the window does not show at the ports while it happens. It shows only at the next power-up that should have completed a burst, or should not have, and the profile code is then off by one step at that very edge. The sweep therefore steps power-ups at spacings on both sides of the window edge and compares the code and IDs one cycle after every power-up. A wrong ring order or a wrong ID table shows at once, on the first advance that reaches the faulty entry.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

    typedef enum logic [1:0] {
        PROF_NONE = 2'd0,
        PROF_ID1  = 2'd1,
        PROF_ID2  = 2'd2
    } prof_e;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_OPEN = 1'b1
    } burst_e;

    localparam logic [15:0] ID1_VID = 16'h04B4;
    localparam logic [15:0] ID1_PID = 16'h8613;
    localparam logic [15:0] ID2_VID = 16'h0925;
    localparam logic [15:0] ID2_PID = 16'h3881;

    function automatic prof_e prof_next(prof_e p);
        prof_e n;
        unique case (p)
            PROF_NONE: n = PROF_ID1;
            PROF_ID1:  n = PROF_ID2;
            PROF_ID2:  n = PROF_NONE;
            default:   n = PROF_NONE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pcsel_edge.sv
module pcsel_edge (
    input  logic clk,
    input  logic init_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) level_q <= 1'b0;
        else         level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/pcsel_window.sv
module pcsel_window #(
    parameter int WINDOW = 3000
) (
    input  logic clk,
    input  logic init_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int TW = (WINDOW < 2) ? 1 : $clog2(WINDOW);
    localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n)                     ticks_q <= '0;
        else if (start)                  ticks_q <= '0;
        else if (run && ticks_q != LAST) ticks_q <= ticks_q + 1'b1;
    end

    assign expired = run && (ticks_q == LAST);
endmodule

// File: rtl/pcsel_fsm.sv
module pcsel_fsm
    import pcsel_pkg::*;
#(
    parameter int BURST_LEN = 3,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             init_n,
    input  logic             rise,
    input  logic             expired,
    output logic             start,
    output logic             run,
    output logic             burst_open,
    output logic [CNT_W-1:0] cnt,
    output prof_e            prof
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_LEN - 1);

    burst_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    prof_e            prof_q, prof_d;

    // state register process
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
            prof_q  <= PROF_NONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prof_q  <= prof_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prof_d  = prof_q;
        start   = 1'b0;
        unique case (state_q)
            BS_IDLE: begin
                if (rise) begin
                    state_d = BS_OPEN;
                    cnt_d   = CNT_W'(1);
                    start   = 1'b1;
                end
            end
            BS_OPEN: begin
                if (rise) begin
                    if (cnt_q == CNT_LAST) begin
                        prof_d  = prof_next(prof_q);
                        cnt_d   = '0;
                        state_d = BS_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else if (expired) begin
                    cnt_d   = '0;
                    state_d = BS_IDLE;
                end
            end
            default: begin
                state_d = BS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign run        = (state_q == BS_OPEN);
    assign burst_open = (state_q == BS_OPEN);
    assign cnt        = cnt_q;
    assign prof       = prof_q;
endmodule

// File: rtl/pcsel_top.sv
module pcsel_top
    import pcsel_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int WINDOW_SEC    = 3,
    parameter int BURST_LEN     = 3
) (
    input  logic        clk,
    input  logic        store_init_n,
    input  logic        power_ok,
    output logic [1:0]  prof_code,
    output logic [15:0] vid,
    output logic [15:0] pid
);
    localparam int WINDOW = TICKS_PER_SEC * WINDOW_SEC;
    localparam int CNT_W  = $clog2(BURST_LEN + 1);

    logic             edge_rise;
    logic             win_start;
    logic             win_run;
    logic             win_expired;
    logic             burst_open;
    logic [CNT_W-1:0] burst_cnt;
    prof_e            prof;

    pcsel_edge u_edge (
        .clk    (clk),
        .init_n (store_init_n),
        .level  (power_ok),
        .rise   (edge_rise)
    );

    pcsel_window #(.WINDOW(WINDOW)) u_win (
        .clk     (clk),
        .init_n  (store_init_n),
        .start   (win_start),
        .run     (win_run),
        .expired (win_expired)
    );

    pcsel_fsm #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .init_n     (store_init_n),
        .rise       (edge_rise),
        .expired    (win_expired),
        .start      (win_start),
        .run        (win_run),
        .burst_open (burst_open),
        .cnt        (burst_cnt),
        .prof       (prof)
    );

    // output process
    always_comb begin
        prof_code = prof;
        unique case (prof)
            PROF_ID1: begin vid = ID1_VID; pid = ID1_PID; end
            PROF_ID2: begin vid = ID2_VID; pid = ID2_PID; end
            default:  begin vid = 16'h0000; pid = 16'h0000; end
        endcase
    end
endmodule

// File: rtl/pcsel_chk.sv
module pcsel_chk #(
    parameter int BURST_LEN = 3,
    parameter int CNT_W     = 2
) (
    input logic             clk,
    input logic             store_init_n,
    input logic             rise,
    input logic             expired,
    input logic             burst_open,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       prof_code,
    input logic [15:0]      vid,
    input logic [15:0]      pid
);
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!store_init_n)
        prof_code != 2'd3);

    assert_none_ids_R2: assert property (@(posedge clk) disable iff (!store_init_n)
        (prof_code == 2'd0) |-> (vid == 16'h0000 && pid == 16'h0000));

    assert_change_needs_rise_R3: assert property (@(posedge clk) disable iff (!store_init_n)
        !rise |=> (prof_code == $past(prof_code)));

    assert_ring_step_R5: assert property (@(posedge clk) disable iff (!store_init_n)
        (prof_code != $past(prof_code)) |->
        (prof_code == (($past(prof_code) == 2'd2) ? 2'd0 : $past(prof_code) + 2'd1)));

    assert_expire_clears_R6: assert property (@(posedge clk) disable iff (!store_init_n)
        (expired && !rise) |=> (cnt == '0 && !burst_open));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!store_init_n)
        cnt < CNT_W'(BURST_LEN));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!store_init_n)
        !burst_open |-> (cnt == '0));
endmodule

bind pcsel_top pcsel_chk #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .store_init_n (store_init_n),
    .rise         (edge_rise),
    .expired      (win_expired),
    .burst_open   (burst_open),
    .cnt          (burst_cnt),
    .prof_code    (prof_code),
    .vid          (vid),
    .pid          (pid)
);

// File: tb/sim_pcsel_top.sv
module sim_pcsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 10;
    localparam int WSEC       = 2;
    localparam int WIN        = TPS * WSEC;
    localparam int BL         = 3;

    logic        clk = 1'b0;
    logic        store_init_n = 1'b0;
    logic        power_ok = 1'b0;
    logic [1:0]  prof_code;
    logic [15:0] vid;
    logic [15:0] pid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcsel_top #(.TICKS_PER_SEC(TPS), .WINDOW_SEC(WSEC), .BURST_LEN(BL)) u0 (
        .clk          (clk),
        .store_init_n (store_init_n),
        .power_ok     (power_ok),
        .prof_code    (prof_code),
        .vid          (vid),
        .pid          (pid)
    );

    int checks = 0;
    int fails  = 0;
    int tnow   = 0;
    int m_prof = 0;
    int m_n    = 0;
    int m_start = 0;
    bit m_open = 0;
    bit done   = 0;

    function automatic int exp_vid(int p);
        return (p == 1) ? 'h04B4 : (p == 2) ? 'h0925 : 0;
    endfunction

    function automatic int exp_pid(int p);
        return (p == 1) ? 'h8613 : (p == 2) ? 'h3881 : 0;
    endfunction

    task automatic step();
        @(posedge clk);
        tnow++;
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, tnow, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        check(tag, int'(prof_code), m_prof);
        check("R2 vid", int'(vid), exp_vid(m_prof));
        check("R2 pid", int'(pid), exp_pid(m_prof));
    endtask

    // requirement model of one power-up at cycle tnow
    task automatic model_event(output string tag);
        if (!m_open || (tnow - m_start) > WIN) begin
            tag     = m_open ? "R6" : "R3";
            m_open  = 1;
            m_start = tnow;
            m_n     = 1;
        end else begin
            m_n++;
            tag = "R3";
            if (m_n == BL) begin
                m_prof = (m_prof + 1) % 3;
                m_open = 0;
                tag    = "R4";
            end
        end
    endtask

    task automatic pulse(int off, int on);
        string tag;
        power_ok = 1'b0;
        repeat (off) step();
        power_ok = 1'b1;
        step();
        model_event(tag);
        check_outs(tag);
        repeat (on - 1) step();
    endtask

    task automatic settle();
        power_ok = 1'b1;
        repeat (WIN + 3) step();
        check_outs("R9");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        int gaps[7] = '{2, 4, 6, 7, 10, 11, 21};
        int p0;
        repeat (3) @(negedge clk);
        check_outs("R1");
        store_init_n = 1'b1;
        step();
        check_outs("R1");

        foreach (gaps[g]) begin
            for (int n = 1; n <= 5; n++) begin
                for (int i = 0; i < n; i++) pulse(1, gaps[g] - 1);
                settle();
            end
        end

        // R8: long power loss leaves everything retained
        power_ok = 1'b0;
        repeat (150) step();
        check_outs("R8");
        pulse(1, 2);
        power_ok = 1'b0;
        repeat (7) step();
        check_outs("R8");
        pulse(5, 2);
        pulse(3, 3);
        settle();

        // R7: five quick power-ups advance exactly once
        p0 = m_prof;
        for (int i = 0; i < 5; i++) pulse(1, 1);
        check("R7", int'(prof_code), (p0 + 1) % 3);
        settle();

        // R5: full trip around the ring
        for (int k = 1; k <= 3; k++) begin
            p0 = m_prof;
            for (int i = 0; i < BL; i++) pulse(1, 2);
            check("R5", int'(prof_code), (p0 + 1) % 3);
            settle();
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule